// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller

This block is a general-purpose I/O port that sits behind a simple register bus. Software reads the levels of a group of lines, drives chosen lines high or low through atomic bit-set and bit-clear registers, and turns each line into an input or an output. Two direction registers with opposite polarity both view one shared direction state, so software may use either convention.

Each line has its own output-enable. A line drives its latched value only while it is an output. Every pad level passes through a two-stage synchroniser before software can read it. A build option mirrors the line-to-bit mapping in every register, so that line 0 sits in the most significant bit. A second build option removes the clear register; the set register then loads the whole output latch.

Top module: `mmio_gpio`

## Requirements
- R1: While reset is held and in the cycle after it is released, every line is an input (pad_oe all 0), pad_out is all 0, and bus_rvalid is 0.
- R2: Reading offset 0 (data register) returns each pad level after a two-flop synchroniser. A pad change made before clock edge E shows up in a read issued at edge E+2. A read issued at E+1 still returns the old level. This applies to output lines as well.
- R3: With the clear register present, writing offset 1 (set register) sets the latch bits written as 1 and leaves the bits written as 0 unchanged.
- R4: With the clear register present, writing offset 2 (clear register) clears the latch bits written as 1 and leaves the bits written as 0 unchanged.
- R5: Built without a clear register, a write to offset 1 loads the whole latch (0 drives low). Writes to offset 2 are ignored and offset 2 reads 0.
- R6: Writing offset 0 loads the whole output latch.
- R7: Writing offset 3 (output-direction register) makes a line an output where the bit is 1 and an input where it is 0. pad_oe shows the direction of each line.
- R8: Writing offset 4 (input-direction register) makes a line an input where the bit is 1 and an output where it is 0. Offsets 3 and 4 always read back as exact complements, whichever of the two was written last.
- R9: pad_out of a line equals its latch bit while the line is an output, and is 0 while the line is an input.
- R10: With mirroring enabled, line n maps to register bit WIDTH-1-n in every register, for both reads and writes.
- R11: Reading offset 1 returns the output latch value, whatever the direction of each line.
- R12: bus_rvalid rises exactly one cycle after a read strobe, with bus_rdata valid at the same time. Offsets 5 to 7 read 0 and ignore writes. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | WIDTH | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pad_in | input | WIDTH | Pad levels (asynchronous) |
| pad_out | output | WIDTH | Pad drive values, per line |
| pad_oe | output | WIDTH | Pad output enables, per line |

## Verification
The assertions check, on every cycle, the parts that are local in time:
- the effect of each write kind on the latch and on pad_oe, including the mirrored mapping and the set-only variant;
- that an input line never drives;
- the one-cycle read response.

The exact synchroniser latency, the complementary read-back of the two direction registers, and read-before-write ordering all show up only in read data. The cycle-accurate reference model in the bench exposes them, using two instances (plain with clear, mirrored without clear) that receive the same traffic.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int GPIO_ADDR_W = 3;

    typedef enum logic [GPIO_ADDR_W-1:0] {
        REG_DATA   = 3'd0,
        REG_SET    = 3'd1,
        REG_CLR    = 3'd2,
        REG_DIROUT = 3'd3,
        REG_DIRIN  = 3'd4
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.stage1 = async_in;
        sy_d.stage2 = sy_q.stage1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign sync_out = sy_q.stage2;
endmodule

// File: rtl/gpio_lane_map.sv
module gpio_lane_map #(
    parameter int WIDTH  = 32,
    parameter bit MIRROR = 1'b0
) (
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst
);
    for (genvar n = 0; n < WIDTH; n++) begin : g_lane
        if (MIRROR) begin : g_rev
            assign dst[n] = src[WIDTH-1-n];
        end else begin : g_id
            assign dst[n] = src[n];
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter bit HAS_CLR = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [GPIO_ADDR_W-1:0] addr,
    input  logic                   wr,
    input  logic [WIDTH-1:0]       wlines,
    input  logic                   rd,
    input  logic [WIDTH-1:0]       sync_lines,
    output logic [WIDTH-1:0]       lat_lines,
    output logic [WIDTH-1:0]       dir_lines,
    output logic [WIDTH-1:0]       rd_lines,
    output logic                   rd_valid
);
    typedef struct packed {
        logic [WIDTH-1:0] lat;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] rdata;
        logic             rvalid;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [WIDTH-1:0] rd_mux;

    always_comb begin
        unique case (addr)
            REG_DATA:   rd_mux = sync_lines;
            REG_SET:    rd_mux = rg_q.lat;
            REG_DIROUT: rd_mux = rg_q.dir;
            REG_DIRIN:  rd_mux = ~rg_q.dir;
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        rg_d        = rg_q;
        rg_d.rvalid = rd;
        if (rd) rg_d.rdata = rd_mux;
        if (wr) begin
            unique case (addr)
                REG_DATA:   rg_d.lat = wlines;
                REG_SET:    rg_d.lat = HAS_CLR ? (rg_q.lat | wlines) : wlines;
                REG_CLR:    if (HAS_CLR) rg_d.lat = rg_q.lat & ~wlines;
                REG_DIROUT: rg_d.dir = wlines;
                REG_DIRIN:  rg_d.dir = ~wlines;
                default:    rg_d.lat = rg_q.lat;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign lat_lines = rg_q.lat;
    assign dir_lines = rg_q.dir;
    assign rd_lines  = rg_q.rdata;
    assign rd_valid  = rg_q.rvalid;
endmodule

// File: rtl/mmio_gpio.sv
module mmio_gpio
    import gpio_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter bit MIRROR  = 1'b0,
    parameter bit HAS_CLR = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [GPIO_ADDR_W-1:0] bus_addr,
    input  logic                   bus_wr,
    input  logic [WIDTH-1:0]       bus_wdata,
    input  logic                   bus_rd,
    output logic [WIDTH-1:0]       bus_rdata,
    output logic                   bus_rvalid,
    input  logic [WIDTH-1:0]       pad_in,
    output logic [WIDTH-1:0]       pad_out,
    output logic [WIDTH-1:0]       pad_oe
);
    if (WIDTH != 8 && WIDTH != 16 && WIDTH != 32 && WIDTH != 64) begin : g_bad_width
        $error("mmio_gpio: WIDTH must be 8, 16, 32 or 64");
    end

    logic [WIDTH-1:0] wr_lines;
    logic [WIDTH-1:0] sync_lines;
    logic [WIDTH-1:0] lat_lines;
    logic [WIDTH-1:0] dir_lines;
    logic [WIDTH-1:0] rd_lines;

    gpio_lane_map #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_map_wr (
        .src(bus_wdata),
        .dst(wr_lines)
    );

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pad_in),
        .sync_out(sync_lines)
    );

    gpio_regs #(.WIDTH(WIDTH), .HAS_CLR(HAS_CLR)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .wlines    (wr_lines),
        .rd        (bus_rd),
        .sync_lines(sync_lines),
        .lat_lines (lat_lines),
        .dir_lines (dir_lines),
        .rd_lines  (rd_lines),
        .rd_valid  (bus_rvalid)
    );

    gpio_lane_map #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_map_rd (
        .src(rd_lines),
        .dst(bus_rdata)
    );

    assign pad_oe  = dir_lines;
    assign pad_out = lat_lines & dir_lines;
endmodule

// File: rtl/mmio_gpio_chk.sv
module mmio_gpio_chk
    import gpio_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter bit MIRROR  = 1'b0,
    parameter bit HAS_CLR = 1'b1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [GPIO_ADDR_W-1:0] bus_addr,
    input logic                   bus_wr,
    input logic [WIDTH-1:0]       bus_wdata,
    input logic                   bus_rd,
    input logic                   bus_rvalid,
    input logic [WIDTH-1:0]       pad_out,
    input logic [WIDTH-1:0]       pad_oe,
    input logic [WIDTH-1:0]       lat_lines
);
    logic [WIDTH-1:0] wl;
    always_comb begin
        for (int n = 0; n < WIDTH; n++)
            wl[n] = MIRROR ? bus_wdata[WIDTH-1-n] : bus_wdata[n];
    end

    // R1: lines come out of reset as non-driving inputs
    p_reset_idle_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && !bus_rvalid));

    // R3 and R10: set register only raises the written lines
    p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_CLR && bus_wr && bus_addr == REG_SET) |=>
        (((lat_lines & $past(wl)) == $past(wl)) &&
         ((lat_lines & ~$past(wl)) == ($past(lat_lines) & ~$past(wl)))));

    // R4 and R10: clear register only lowers the written lines
    p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_CLR && bus_wr && bus_addr == REG_CLR) |=>
        (((lat_lines & $past(wl)) == '0) &&
         ((lat_lines & ~$past(wl)) == ($past(lat_lines) & ~$past(wl)))));

    // R5: without a clear register the set register loads the latch
    p_set_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_CLR && bus_wr && bus_addr == REG_SET) |=> (lat_lines == $past(wl)));

    // R5: without a clear register its offset leaves the latch alone
    p_clr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_CLR && bus_wr && bus_addr == REG_CLR) |=> $stable(lat_lines));

    // R6: data register write loads the latch
    p_data_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DATA) |=> (lat_lines == $past(wl)));

    // R7: output-direction write sets the enables directly
    p_dirout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DIROUT) |=> (pad_oe == $past(wl)));

    // R8: input-direction write sets the inverted enables
    p_dirin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DIRIN) |=> (pad_oe == ~$past(wl)));

    // R9: an input line never drives high
    p_no_drive_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

    // R12: read response one cycle after the strobe
    p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    p_rvalid_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
endmodule

bind mmio_gpio mmio_gpio_chk #(
    .WIDTH(WIDTH), .MIRROR(MIRROR), .HAS_CLR(HAS_CLR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rvalid(bus_rvalid),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .lat_lines (lat_lines)
);

// File: tb/tb_mmio_gpio.sv
module tb_mmio_gpio;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   addr = '0;
    logic         wr = 1'b0;
    logic         rd = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] pin = '0;

    logic [W-1:0] g_rdata [2];
    logic         g_rv    [2];
    logic [W-1:0] g_po    [2];
    logic [W-1:0] g_oe    [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    // instance 0: plain order, with clear register
    mmio_gpio #(.WIDTH(W), .MIRROR(1'b0), .HAS_CLR(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(g_rdata[0]),
        .bus_rvalid(g_rv[0]), .pad_in(pin), .pad_out(g_po[0]), .pad_oe(g_oe[0])
    );

    // instance 1: mirrored order (R10), set register loads the latch (R5)
    mmio_gpio #(.WIDTH(W), .MIRROR(1'b1), .HAS_CLR(1'b0)) dut_m (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(g_rdata[1]),
        .bus_rvalid(g_rv[1]), .pad_in(pin), .pad_out(g_po[1]), .pad_oe(g_oe[1])
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string phase = "R1";

    // behavioural reference state
    logic [W-1:0] m_lat [2];
    logic [W-1:0] m_dir [2];
    logic [W-1:0] m_rd  [2];
    logic         m_rv  [2];
    logic [W-1:0] m_s1, m_s2;

    function automatic logic [W-1:0] remap(int i, logic [W-1:0] v);
        logic [W-1:0] r;
        for (int n = 0; n < W; n++) r[n] = (i == 1) ? v[W-1-n] : v[n];
        return r;
    endfunction

    function automatic logic [W-1:0] model_read(int i);
        case (addr)
            3'd0:    return remap(i, m_s2);
            3'd1:    return remap(i, m_lat[i]);
            3'd3:    return remap(i, m_dir[i]);
            3'd4:    return remap(i, ~m_dir[i]);
            default: return '0;
        endcase
    endfunction

    task automatic model_edge();
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                m_lat[i] = '0; m_dir[i] = '0; m_rd[i] = '0; m_rv[i] = 1'b0;
            end else begin
                logic [W-1:0] wl;
                wl = remap(i, wdata);
                m_rv[i] = rd;
                if (rd) m_rd[i] = model_read(i);
                if (wr) begin
                    case (addr)
                        3'd0: m_lat[i] = wl;
                        3'd1: m_lat[i] = (i == 0) ? (m_lat[i] | wl) : wl;
                        3'd2: if (i == 0) m_lat[i] = m_lat[i] & ~wl;
                        3'd3: m_dir[i] = wl;
                        3'd4: m_dir[i] = ~wl;
                        default: ;
                    endcase
                end
            end
        end
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0;
        end else begin
            m_s2 = m_s1; m_s1 = pin;
        end
    endtask

    task automatic cmp(string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int i = 0; i < 2; i++) begin
            string tg;
            tg = (i == 1) ? "dut_m(R10)" : "dut";
            cmp($sformatf("%s pad_oe R7", tg), g_oe[i], m_dir[i]);
            cmp($sformatf("%s pad_out R9", tg), g_po[i], m_lat[i] & m_dir[i]);
            cmp($sformatf("%s rvalid R12", tg), {{(W-1){1'b0}}, g_rv[i]},
                {{(W-1){1'b0}}, m_rv[i]});
            if (m_rv[i]) cmp($sformatf("%s rdata", tg), g_rdata[i], m_rd[i]);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic op(bit w, bit r, logic [2:0] a, logic [W-1:0] d);
        wr = w; rd = r; addr = a; wdata = d;
        step();
    endtask

    task automatic idle(int n);
        wr = 1'b0; rd = 1'b0;
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired in phase %s actual=hung expected=finished", phase);
            report();
            $finish;
        end
    end

    initial begin
        // R1: reset state, held and just released
        phase = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R7, R8: direction registers, shared state read back both ways
        phase = "R7";
        op(1, 0, 3'd3, 16'h00FF);
        op(0, 1, 3'd3, 16'h0);
        op(0, 1, 3'd4, 16'h0);
        phase = "R8";
        op(1, 0, 3'd4, 16'h0F0F);
        op(0, 1, 3'd3, 16'h0);
        op(0, 1, 3'd4, 16'h0);
        op(1, 0, 3'd3, 16'hFFFF);

        // R3 / R5: set register, R11 read-back of the latch
        phase = "R3";
        op(1, 0, 3'd1, 16'h0013);
        op(1, 0, 3'd1, 16'h0100);
        phase = "R11";
        op(0, 1, 3'd1, 16'h0);

        // R4 / R5: clear register (ignored on the set-only instance)
        phase = "R4";
        op(1, 0, 3'd2, 16'h0011);
        op(0, 1, 3'd1, 16'h0);
        phase = "R5";
        op(0, 1, 3'd2, 16'h0);
        op(1, 0, 3'd2, 16'hFFFF);
        op(0, 1, 3'd1, 16'h0);

        // R6: data register write loads the latch
        phase = "R6";
        op(1, 0, 3'd0, 16'hA5C3);
        op(0, 1, 3'd1, 16'h0);

        // R9: half the lines back to inputs, latch kept
        phase = "R9";
        op(1, 0, 3'd4, 16'hF0F0);
        op(0, 1, 3'd1, 16'h0);

        // R2: synchroniser latency, back-to-back data reads after a pad change
        phase = "R2";
        idle(3);
        pin = 16'h1234;
        for (int k = 0; k < 4; k++) op(0, 1, 3'd0, 16'h0);
        pin = 16'hBEEF;
        op(0, 1, 3'd0, 16'h0);
        pin = 16'h0001;
        for (int k = 0; k < 3; k++) op(0, 1, 3'd0, 16'h0);

        // R12: unmapped offsets, read together with write
        phase = "R12";
        for (int a = 5; a < 8; a++) begin
            op(1, 1, 3'(a), 16'hFFFF);
            op(0, 1, 3'(a), 16'h0);
        end
        op(1, 1, 3'd1, 16'h8000);
        op(1, 1, 3'd3, 16'h1234);
        op(0, 1, 3'd1, 16'h0);

        // R10: mixed random traffic through both instances
        phase = "R10";
        for (int k = 0; k < 400; k++) begin
            pin = 16'($urandom);
            op(1'($urandom), 1'($urandom), 3'($urandom), 16'($urandom));
        end
        idle(3);

        // R1: reset again mid-run
        phase = "R1";
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(2);

        done = 1'b1;
        report();
        $finish;
    end
endmodule